// File: doc/BRIEF.md
# Spare-Word Memory Repair Array

This block sits beside a word-oriented main memory and repairs it word by word with a few spare entries. Each spare entry holds a valid flag, the address of a faulty word and a replacement data word. While the chip runs its memory self-test, the block is in test-and-repair mode. In that mode the self-test logic drives the memory, and every fault it detects arrives as a one-cycle fault pulse, together with the failing address and the data that should have been read. The block stores that pair in the next free spare entry. When all entries are taken it raises overflow, which means the memory cannot be repaired.

In normal mode the user's address, data and read/write strobes are steered to the main memory. Every user address is also compared against all programmed entries. A write that hits an entry updates the spare data. A read that hits an entry returns the spare data in place of the main memory output. The main memory returns read data one cycle after the read strobe. The block registers its own hit decision to match, so the repaired read data is valid in that same later cycle.

Top module: `spare_word_repair`

## Requirements
- R1: After reset, overflow is low and no entry is programmed, so every normal-mode read returns the main memory data.
- R2: In test mode, a fault pulse on an address held by no entry programs the lowest free entry with that address and data. A later normal-mode read of that address returns the programmed data.
- R3: A fault pulse on an address already held by an entry does not take a new entry. It only replaces that entry's data.
- R4: Overflow goes high in the cycle after the pulse that fills the last free entry.
- R5: Once overflow is high, fault pulses change nothing: no new address is repaired, no held data is replaced, and overflow stays high until reset.
- R6: A fault pulse while the mode input is low (normal mode) has no effect.
- R7: With the mode input high, the memory-side address, write data, read enable and write enable copy the test-side inputs. With it low, they copy the user-side inputs.
- R8: A normal-mode write to a programmed address updates the spare data. A read of that address one or more cycles later returns the new value.
- R9: Read data appears one cycle after the read enable. On a normal-mode read that hits no entry, it equals the main memory read data.
- R10: In test mode, the read data always passes the main memory output through, even for a programmed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | 1 = test-and-repair mode, 0 = normal mode |
| faultPulse | input | 1 | One-cycle fault strobe from the self-test logic |
| faultAddr | input | ADDR_W | Address of the detected faulty word |
| faultData | input | DATA_W | Correct data for the faulty word |
| bistAddr | input | ADDR_W | Test-side memory address |
| bistWrData | input | DATA_W | Test-side write data |
| bistRdEn | input | 1 | Test-side read enable |
| bistWrEn | input | 1 | Test-side write enable |
| userAddr | input | ADDR_W | Normal-mode address |
| userWrData | input | DATA_W | Normal-mode write data |
| userRdEn | input | 1 | Normal-mode read enable |
| userWrEn | input | 1 | Normal-mode write enable |
| memAddr | output | ADDR_W | Address to the main memory |
| memWrData | output | DATA_W | Write data to the main memory |
| memRdEn | output | 1 | Read enable to the main memory |
| memWrEn | output | 1 | Write enable to the main memory |
| memRdData | input | DATA_W | Main memory read data, one cycle after memRdEn |
| rdData | output | DATA_W | Repaired read data |
| overflow | output | 1 | All spare entries used; no further repair possible |

## Verification
The memory-side outputs are combinational and are due in the same cycle as the inputs. Programming, refresh and overflow take effect at the next clock edge. Read data is due one edge after the read enable is sampled. The bench drives inputs just after a rising edge and keeps a reference model that advances on each rising edge. It compares every output at the following falling edge, so each result is sampled exactly one register stage after its cause. Directed reads follow each programming step with an idle cycle and then sample rdData, which checks the one-cycle read latency explicitly.

// File: rtl/swr_pkg.sv
package swr_pkg;
  // Strobes from the control unit to the spare-entry datapath.
  typedef struct packed {
    logic allocEn;    // write addr+data and set flag of entry allocIdx
    logic refreshEn;  // replace data of the entry hit by faultAddr
    logic inEn;       // replace data of the entry hit by userAddr
    logic outEn;      // select spare data for the read in flight
  } swr_strobe_t;
endpackage

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
#(
  parameter int NUM_SPARES = 4,
  localparam int IDX_W = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1,
  localparam int CNT_W = $clog2(NUM_SPARES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic             faultPulse,
  input  logic             faultHitAny,
  input  logic             userHitAny,
  input  logic             userRdEn,
  input  logic             userWrEn,
  output swr_strobe_t      strobe,
  output logic [IDX_W-1:0] allocIdx,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SPARES - 1);

  logic [CNT_W-1:0] usedCnt;
  logic             fullQ;
  logic             faultGo;

  assign faultGo = testMode & faultPulse & ~fullQ;

  always_comb begin
    strobe.allocEn   = faultGo & ~faultHitAny;
    strobe.refreshEn = faultGo & faultHitAny;
    strobe.inEn      = ~testMode & userWrEn & userHitAny;
    strobe.outEn     = ~testMode & userRdEn & userHitAny;
  end

  assign allocIdx = usedCnt[IDX_W-1:0];
  assign overflow = fullQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedCnt <= '0;
      fullQ   <= 1'b0;
    end else if (strobe.allocEn) begin
      usedCnt <= usedCnt + 1'b1;
      if (usedCnt == LAST) fullQ <= 1'b1;
    end
  end
endmodule

// File: rtl/swr_datapath.sv
module swr_datapath
  import swr_pkg::*;
#(
  parameter int NUM_SPARES = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  localparam int IDX_W = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  testMode,
  input  swr_strobe_t           strobe,
  input  logic [IDX_W-1:0]      allocIdx,
  input  logic [ADDR_W-1:0]     faultAddr,
  input  logic [DATA_W-1:0]     faultData,
  input  logic [ADDR_W-1:0]     bistAddr,
  input  logic [DATA_W-1:0]     bistWrData,
  input  logic                  bistRdEn,
  input  logic                  bistWrEn,
  input  logic [ADDR_W-1:0]     userAddr,
  input  logic [DATA_W-1:0]     userWrData,
  input  logic                  userRdEn,
  input  logic                  userWrEn,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWrData,
  output logic                  memRdEn,
  output logic                  memWrEn,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_SPARES-1:0] flagVec,
  output logic [NUM_SPARES-1:0] faultHitVec,
  output logic [NUM_SPARES-1:0] userHitVec
);
  logic [ADDR_W-1:0] addrQ [NUM_SPARES];
  logic [DATA_W-1:0] dataQ [NUM_SPARES];
  logic [DATA_W-1:0] hitData;
  logic [DATA_W-1:0] spareQ;
  logic              rdSelQ;

  // input multiplexer toward the main memory
  assign memAddr   = testMode ? bistAddr   : userAddr;
  assign memWrData = testMode ? bistWrData : userWrData;
  assign memRdEn   = testMode ? bistRdEn   : userRdEn;
  assign memWrEn   = testMode ? bistWrEn   : userWrEn;

  for (genvar i = 0; i < NUM_SPARES; i++) begin : g_entry
    assign faultHitVec[i] = flagVec[i] && (addrQ[i] == faultAddr);
    assign userHitVec[i]  = flagVec[i] && (addrQ[i] == userAddr);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagVec[i] <= 1'b0;
        addrQ[i]   <= '0;
        dataQ[i]   <= '0;
      end else if (strobe.allocEn && (allocIdx == IDX_W'(i))) begin
        flagVec[i] <= 1'b1;
        addrQ[i]   <= faultAddr;
        dataQ[i]   <= faultData;
      end else if (strobe.refreshEn && faultHitVec[i]) begin
        dataQ[i]   <= faultData;
      end else if (strobe.inEn && userHitVec[i]) begin
        dataQ[i]   <= userWrData;
      end
    end
  end

  always_comb begin
    hitData = '0;
    for (int i = 0; i < NUM_SPARES; i++)
      if (userHitVec[i]) hitData = hitData | dataQ[i];
  end

  // align the spare read with the memory's one-cycle read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSelQ <= 1'b0;
      spareQ <= '0;
    end else begin
      rdSelQ <= strobe.outEn;
      if (strobe.outEn) spareQ <= hitData;
    end
  end

  // output multiplexer
  assign rdData = rdSelQ ? spareQ : memRdData;
endmodule

// File: rtl/spare_word_repair.sv
module spare_word_repair
  import swr_pkg::*;
#(
  parameter int NUM_SPARES = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  localparam int IDX_W = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              faultPulse,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [DATA_W-1:0] faultData,
  input  logic [ADDR_W-1:0] bistAddr,
  input  logic [DATA_W-1:0] bistWrData,
  input  logic              bistRdEn,
  input  logic              bistWrEn,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userWrData,
  input  logic              userRdEn,
  input  logic              userWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic              memWrEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              overflow
);
  swr_strobe_t           strobe;
  logic [IDX_W-1:0]      allocIdx;
  logic [NUM_SPARES-1:0] flagVec;
  logic [NUM_SPARES-1:0] faultHitVec;
  logic [NUM_SPARES-1:0] userHitVec;
  logic                  allocEn;

  assign allocEn = strobe.allocEn;

  swr_ctrl #(.NUM_SPARES(NUM_SPARES)) u_ctrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .faultPulse(faultPulse),
    .faultHitAny(|faultHitVec), .userHitAny(|userHitVec),
    .userRdEn(userRdEn), .userWrEn(userWrEn),
    .strobe(strobe), .allocIdx(allocIdx), .overflow(overflow)
  );

  swr_datapath #(.NUM_SPARES(NUM_SPARES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .testMode(testMode), .strobe(strobe), .allocIdx(allocIdx),
    .faultAddr(faultAddr), .faultData(faultData),
    .bistAddr(bistAddr), .bistWrData(bistWrData), .bistRdEn(bistRdEn), .bistWrEn(bistWrEn),
    .userAddr(userAddr), .userWrData(userWrData), .userRdEn(userRdEn), .userWrEn(userWrEn),
    .memRdData(memRdData), .memAddr(memAddr), .memWrData(memWrData),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .rdData(rdData),
    .flagVec(flagVec), .faultHitVec(faultHitVec), .userHitVec(userHitVec)
  );
endmodule

// File: rtl/spare_word_repair_chk.sv
module spare_word_repair_chk #(
  parameter int NUM_SPARES = 4,
  parameter int DATA_W     = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  testMode,
  input logic                  bistRdEn,
  input logic                  userRdEn,
  input logic [DATA_W-1:0]     rdData,
  input logic [DATA_W-1:0]     memRdData,
  input logic                  overflow,
  input logic                  allocEn,
  input logic [NUM_SPARES-1:0] flagVec,
  input logic [NUM_SPARES-1:0] userHitVec
);
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  a_r4_full_when_overflow: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (&flagVec));

  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(userHitVec));

  a_r2_alloc_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |=> ($countones(flagVec) == $past($countones(flagVec)) + 1));

  a_r10_test_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && bistRdEn) |=> (rdData == memRdData));

  a_r9_miss_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && userRdEn && (userHitVec == '0)) |=> (rdData == memRdData));
endmodule

bind spare_word_repair spare_word_repair_chk #(.NUM_SPARES(NUM_SPARES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .testMode(testMode), .bistRdEn(bistRdEn), .userRdEn(userRdEn),
  .rdData(rdData), .memRdData(memRdData), .overflow(overflow), .allocEn(allocEn),
  .flagVec(flagVec), .userHitVec(userHitVec)
);

// File: tb/spare_word_repair_tb.sv
module spare_word_repair_tb;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0, faultPulse = 1'b0;
  logic [AW-1:0] faultAddr = '0, bistAddr = '0, userAddr = '0;
  logic [DW-1:0] faultData = '0, bistWrData = '0, userWrData = '0;
  logic bistRdEn = 1'b0, bistWrEn = 1'b0, userRdEn = 1'b0, userWrEn = 1'b0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData, rdData;
  logic memRdEn, memWrEn, overflow;
  logic [DW-1:0] memRdData = '0;
  logic [DW-1:0] memArr [256];

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spare_word_repair #(.NUM_SPARES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .testMode(testMode), .faultPulse(faultPulse),
    .faultAddr(faultAddr), .faultData(faultData), .bistAddr(bistAddr),
    .bistWrData(bistWrData), .bistRdEn(bistRdEn), .bistWrEn(bistWrEn),
    .userAddr(userAddr), .userWrData(userWrData), .userRdEn(userRdEn),
    .userWrEn(userWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memRdData(memRdData),
    .rdData(rdData), .overflow(overflow)
  );

  // main memory: one-cycle read latency
  always @(posedge clk) begin
    if (memWrEn) memArr[memAddr] <= memWrData;
    if (memRdEn) memRdData <= memArr[memAddr];
  end

  // reference model
  int spAddr [N];
  int spData [N];
  int used = 0;
  bit expSel = 0;
  int expSpare = 0;
  string rdTag = "R9";

  function automatic int findHit(int a);
    for (int i = 0; i < used; i++) if (spAddr[i] == a) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      used = 0; expSel = 0; expSpare = 0; rdTag = "R1";
    end else begin
      int h;
      h = findHit(int'(userAddr));
      if (!testMode && userRdEn && h >= 0) begin
        expSel = 1; expSpare = spData[h]; rdTag = "R8";
      end else begin
        expSel = 0;
        rdTag = testMode ? "R10" : "R9";
      end
      if (!testMode && userWrEn && h >= 0) spData[h] = int'(userWrData);
      if (testMode && faultPulse && used < N) begin
        int f;
        f = findHit(int'(faultAddr));
        if (f >= 0) spData[f] = int'(faultData);
        else begin
          spAddr[used] = int'(faultAddr); spData[used] = int'(faultData); used++;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rdTag, int'(rdData), expSel ? expSpare : int'(memRdData));
      check("R4", int'(overflow), int'(used == N));
      check("R7", int'(memAddr), testMode ? int'(bistAddr) : int'(userAddr));
      check("R7", int'(memWrData), testMode ? int'(bistWrData) : int'(userWrData));
      check("R7", int'({memRdEn, memWrEn}),
            testMode ? int'({bistRdEn, bistWrEn}) : int'({userRdEn, userWrEn}));
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    faultPulse = 0; bistRdEn = 0; bistWrEn = 0; userRdEn = 0; userWrEn = 0;
  endtask

  task automatic uWrite(int a, int d);
    @(posedge clk); #1;
    testMode = 0; userAddr = AW'(a); userWrData = DW'(d); userWrEn = 1; userRdEn = 0;
    idle();
  endtask

  task automatic uRead(int a, int exp, string tag);
    @(posedge clk); #1;
    testMode = 0; userAddr = AW'(a); userRdEn = 1; userWrEn = 0;
    idle();
    @(negedge clk);
    check(tag, int'(rdData), exp);
  endtask

  task automatic bRead(int a, int exp, string tag);
    @(posedge clk); #1;
    testMode = 1; bistAddr = AW'(a); bistRdEn = 1;
    idle();
    @(negedge clk);
    check(tag, int'(rdData), exp);
  endtask

  task automatic fault(bit tm, int a, int d);
    @(posedge clk); #1;
    testMode = tm; faultAddr = AW'(a); faultData = DW'(d); faultPulse = 1;
    idle();
  endtask

  task automatic doReset();
    @(posedge clk); #1; rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", int'(overflow), 0);
    #1 rstN = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(overflow), 0);
    rstN = 1;
    for (int i = 1; i <= 16; i++) uWrite(i, 16'h1000 + i);
    uRead(3, 16'h1003, "R1");
    // R2, R3: program and refresh
    fault(1, 3, 16'hA5A5);
    fault(1, 3, 16'hB6B6);
    @(negedge clk); check("R3", int'(overflow), 0);
    // R6: pulse in normal mode ignored
    fault(0, 7, 16'hDEAD);
    uRead(3, 16'hB6B6, "R2");
    uRead(7, 16'h1007, "R6");
    // R10: raw memory seen in test mode
    bRead(3, 16'h1003, "R10");
    // R8: normal write to repaired address
    uWrite(3, 16'hC3C3);
    uRead(3, 16'hC3C3, "R8");
    uRead(9, 16'h1009, "R9");
    // R4: fill remaining entries
    fault(1, 10, 16'h0A0A);
    fault(1, 11, 16'h0B0B);
    @(negedge clk); check("R4", int'(overflow), 0);
    fault(1, 12, 16'h0C0C);
    @(negedge clk); check("R4", int'(overflow), 1);
    // R5: pulses after overflow ignored
    fault(1, 13, 16'hEEEE);
    fault(1, 3, 16'hFFFF);
    uRead(13, 16'h100D, "R5");
    uRead(3, 16'hC3C3, "R5");
    uRead(12, 16'h0C0C, "R2");
    repeat (3) idle();
    @(negedge clk); check("R5", int'(overflow), 1);
    // R1: reset clears all entries
    doReset();
    uRead(3, 16'hC3C3, "R1");
    uRead(12, 16'h100C, "R1");
    repeat (2) idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule